// File: doc/BRIEF.md
# Hub Block Transfer Engine

The engine copies whole blocks of sixteen 32-bit words between a core's private register file and a shared memory that is split into sixteen slices. A rotator hands the core a different slice on every clock. Instead of waiting for the slice that holds the first word, the engine serves whichever word of the current block sits in the slice on offer. A block therefore fills in rotation order, and its length is fixed whatever the starting phase.

A transfer is launched with a one-cycle start strobe. The strobe carries a shared-memory word address (its low four bits are dropped, so blocks sit on 16-word boundaries), a register-file base index, a block count and a direction. The engine holds busy while it works and gives a one-cycle done pulse when it finishes. Both memories are outside the engine and are read combinationally, in the same cycle as the address.

Top module: `hbx_engine`

## Requirements
- R1: A start strobe with a block count N of 1 or more makes busy high for exactly 16·N cycles, beginning in the cycle after the strobe. done is high for one cycle, in the cycle after the last access, and busy is low in that cycle.
- R2: While the rotator advances by one slice per clock, the engine makes one word access in every busy cycle, including the first, whatever slice is on offer when it starts.
- R3: In a cycle where slice s is on offer during block k (counted from 0), the access goes to shared-memory word {start[HUB_AW-1:4] + k, s}, which is the start word plus 16·k + s, and to register index (base + 16·k + s) modulo 2^LOC_AW.
- R4: dir_i = 0 moves data from shared memory to the register file (loc_we_o high, loc_wdata_o = hub_rdata_i, hub_we_o low). dir_i = 1 moves data from the register file to shared memory (hub_we_o high, hub_wdata_o = loc_rdata_i, loc_we_o low).
- R5: Bits [3:0] of hub_addr_i are ignored. A block always starts at a 16-word boundary.
- R6: A start strobe with a block count of 0 is ignored: busy stays low, there is no done pulse and there are no write strobes.
- R7: A start strobe that arrives while busy is high is ignored. The running transfer finishes with its own parameters, and no second transfer follows it.
- R8: After reset, busy and done are low. No write strobe is ever high while busy is low.
- R9: Each word of a block is moved exactly once. If the rotator offers a slice again before the block is complete (a stall), that cycle makes no access, and the block ends only after all sixteen slices have been served.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | One-cycle launch strobe |
| dir_i | input | 1 | 0: shared memory to register file, 1: register file to shared memory |
| hub_addr_i | input | HUB_AW | Shared-memory start word address (low 4 bits ignored) |
| loc_base_i | input | LOC_AW | Register-file start index |
| blk_cnt_i | input | CNT_W | Number of 16-word blocks |
| slice_i | input | 4 | Slice currently offered by the rotator |
| busy_o | output | 1 | Transfer in progress |
| done_o | output | 1 | One-cycle completion pulse |
| hub_addr_o | output | HUB_AW | Shared-memory word address |
| hub_we_o | output | 1 | Shared-memory write strobe |
| hub_wdata_o | output | DATA_W | Shared-memory write data |
| hub_rdata_i | input | DATA_W | Shared-memory read data (same cycle) |
| loc_addr_o | output | LOC_AW | Register-file index |
| loc_we_o | output | 1 | Register-file write strobe |
| loc_wdata_o | output | DATA_W | Register-file write data |
| loc_rdata_i | input | DATA_W | Register-file read data (same cycle) |

## Verification
The assertions check on every cycle that:
- an access is made in every busy cycle in which the slice advanced;
- no strobe fires while the engine is idle;
- done is a single pulse that coincides with busy falling;
- the coverage mask grows by one word per access;
- the shared-memory address always lands in the slice on offer.

Only the bench's scenarios show whether the word addresses and data match the rotation order expected from the start phase. The same goes for ignoring the low address bits, wrapping the register index, ignoring zero-count and mid-transfer launches, and the one extra cycle that a rotator stall costs.

// File: rtl/hbx_pkg.sv
package hbx_pkg;

    localparam int SLICE_N = 16;
    localparam int SLICE_W = 4;

    typedef logic [SLICE_N-1:0] cover_t;

    typedef enum logic {
        XF_HUB_TO_LOC = 1'b0,
        XF_LOC_TO_HUB = 1'b1
    } xfer_dir_e;

    function automatic cover_t slice_bit(input logic [SLICE_W-1:0] s);
        return cover_t'(1) << s;
    endfunction

endpackage

// File: rtl/hbx_ctrl.sv
module hbx_ctrl #(
    parameter int CNT_W = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start_i,
    input  logic [CNT_W-1:0] blk_cnt_i,
    input  logic             acc_i,
    input  logic             full_i,
    output logic             accept_o,
    output logic             busy_o,
    output logic             done_o,
    output logic [CNT_W-1:0] blk_idx_o
);

    logic             busy_q;
    logic             done_q;
    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] idx_q;
    logic             last_blk;
    logic             blk_end;

    assign accept_o = start_i && !busy_q && (blk_cnt_i != '0);
    assign last_blk = (idx_q == cnt_q - CNT_W'(1));
    assign blk_end  = busy_q && acc_i && full_i;

    always_ff @(posedge clk) begin
        if (rst) begin
            busy_q <= 1'b0;
            done_q <= 1'b0;
            cnt_q  <= '0;
            idx_q  <= '0;
        end else begin
            done_q <= 1'b0;
            if (accept_o) begin
                busy_q <= 1'b1;
                cnt_q  <= blk_cnt_i;
                idx_q  <= '0;
            end else if (blk_end) begin
                if (last_blk) begin
                    busy_q <= 1'b0;
                    done_q <= 1'b1;
                end else begin
                    idx_q <= idx_q + CNT_W'(1);
                end
            end
        end
    end

    assign busy_o    = busy_q;
    assign done_o    = done_q;
    assign blk_idx_o = idx_q;

    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (rst)
        done_q |=> !done_q); // R1
    AST_DONE_IDLE: assert property (@(posedge clk) disable iff (rst)
        done_q |-> !busy_q); // R1
    AST_END_SIGNALLED: assert property (@(posedge clk) disable iff (rst)
        $fell(busy_q) |-> done_q); // R1

endmodule

// File: rtl/hbx_cover.sv
module hbx_cover
    import hbx_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic               clr_i,
    input  logic               busy_i,
    input  logic [SLICE_W-1:0] slice_i,
    output logic               acc_o,
    output logic               full_o
);

    cover_t cov_q;
    cover_t cov_nx;

    assign acc_o  = busy_i && !cov_q[slice_i];
    assign cov_nx = cov_q | slice_bit(slice_i);
    assign full_o = acc_o && (&cov_nx);

    always_ff @(posedge clk) begin
        if (rst || clr_i) begin
            cov_q <= '0;
        end else if (acc_o) begin
            cov_q <= full_o ? '0 : cov_nx;
        end
    end

    AST_COVER_GROWS: assert property (@(posedge clk) disable iff (rst)
        (acc_o && !full_o) |=> ($countones(cov_q) == $past($countones(cov_q)) + 1)); // R9

endmodule

// File: rtl/hbx_addr.sv
module hbx_addr
    import hbx_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int HUB_AW = 10,
    parameter int LOC_AW = 8,
    parameter int CNT_W  = 4
) (
    input  logic                      clk,
    input  logic                      rst,
    input  logic                      accept_i,
    input  logic                      dir_i,
    input  logic [HUB_AW-SLICE_W-1:0] hub_blk_i,
    input  logic [LOC_AW-1:0]         loc_base_i,
    input  logic [CNT_W-1:0]          blk_idx_i,
    input  logic [SLICE_W-1:0]        slice_i,
    input  logic                      acc_i,
    output logic [HUB_AW-1:0]         hub_addr_o,
    output logic                      hub_we_o,
    output logic [DATA_W-1:0]         hub_wdata_o,
    input  logic [DATA_W-1:0]         hub_rdata_i,
    output logic [LOC_AW-1:0]         loc_addr_o,
    output logic                      loc_we_o,
    output logic [DATA_W-1:0]         loc_wdata_o,
    input  logic [DATA_W-1:0]         loc_rdata_i
);

    localparam int HBLK_W = HUB_AW - SLICE_W;

    typedef struct packed {
        xfer_dir_e          dir;
        logic [HBLK_W-1:0]  hblk;
        logic [LOC_AW-1:0]  lbase;
    } req_t;

    req_t              req_q;
    logic [HUB_AW-1:0] hub_off;
    logic [LOC_AW-1:0] loc_off;

    always_ff @(posedge clk) begin
        if (rst) begin
            req_q <= '0;
        end else if (accept_i) begin
            req_q.dir   <= xfer_dir_e'(dir_i);
            req_q.hblk  <= hub_blk_i;
            req_q.lbase <= loc_base_i;
        end
    end

    assign hub_off    = HUB_AW'(blk_idx_i) << SLICE_W;
    assign loc_off    = LOC_AW'(blk_idx_i) << SLICE_W;
    assign hub_addr_o = {req_q.hblk, slice_i} + hub_off;
    assign loc_addr_o = req_q.lbase + loc_off + LOC_AW'(slice_i);

    assign hub_we_o    = acc_i && (req_q.dir == XF_LOC_TO_HUB);
    assign loc_we_o    = acc_i && (req_q.dir == XF_HUB_TO_LOC);
    assign hub_wdata_o = loc_rdata_i;
    assign loc_wdata_o = hub_rdata_i;

    AST_SLICE_LANE: assert property (@(posedge clk) disable iff (rst)
        acc_i |-> (hub_addr_o[SLICE_W-1:0] == slice_i)); // R3

endmodule

// File: rtl/hbx_engine.sv
module hbx_engine
    import hbx_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int HUB_AW = 10,
    parameter int LOC_AW = 8,
    parameter int CNT_W  = 4
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               start_i,
    input  logic               dir_i,
    input  logic [HUB_AW-1:0]  hub_addr_i,
    input  logic [LOC_AW-1:0]  loc_base_i,
    input  logic [CNT_W-1:0]   blk_cnt_i,
    input  logic [SLICE_W-1:0] slice_i,
    output logic               busy_o,
    output logic               done_o,
    output logic [HUB_AW-1:0]  hub_addr_o,
    output logic               hub_we_o,
    output logic [DATA_W-1:0]  hub_wdata_o,
    input  logic [DATA_W-1:0]  hub_rdata_i,
    output logic [LOC_AW-1:0]  loc_addr_o,
    output logic               loc_we_o,
    output logic [DATA_W-1:0]  loc_wdata_o,
    input  logic [DATA_W-1:0]  loc_rdata_i
);

    logic             accept;
    logic             acc;
    logic             full;
    logic [CNT_W-1:0] blk_idx;
    logic             unused_lsb;

    assign unused_lsb = ^hub_addr_i[SLICE_W-1:0];

    hbx_ctrl #(.CNT_W(CNT_W)) u_ctrl (
        .clk       (clk),
        .rst       (rst),
        .start_i   (start_i),
        .blk_cnt_i (blk_cnt_i),
        .acc_i     (acc),
        .full_i    (full),
        .accept_o  (accept),
        .busy_o    (busy_o),
        .done_o    (done_o),
        .blk_idx_o (blk_idx)
    );

    hbx_cover u_cover (
        .clk     (clk),
        .rst     (rst),
        .clr_i   (accept),
        .busy_i  (busy_o),
        .slice_i (slice_i),
        .acc_o   (acc),
        .full_o  (full)
    );

    hbx_addr #(
        .DATA_W (DATA_W),
        .HUB_AW (HUB_AW),
        .LOC_AW (LOC_AW),
        .CNT_W  (CNT_W)
    ) u_addr (
        .clk         (clk),
        .rst         (rst),
        .accept_i    (accept),
        .dir_i       (dir_i),
        .hub_blk_i   (hub_addr_i[HUB_AW-1:SLICE_W]),
        .loc_base_i  (loc_base_i),
        .blk_idx_i   (blk_idx),
        .slice_i     (slice_i),
        .acc_i       (acc),
        .hub_addr_o  (hub_addr_o),
        .hub_we_o    (hub_we_o),
        .hub_wdata_o (hub_wdata_o),
        .hub_rdata_i (hub_rdata_i),
        .loc_addr_o  (loc_addr_o),
        .loc_we_o    (loc_we_o),
        .loc_wdata_o (loc_wdata_o),
        .loc_rdata_i (loc_rdata_i)
    );

    AST_QUIET_IDLE: assert property (@(posedge clk) disable iff (rst)
        !busy_o |-> (!hub_we_o && !loc_we_o)); // R8
    AST_FULL_RATE: assert property (@(posedge clk) disable iff (rst)
        (busy_o && $past(busy_o) && (slice_i == 4'($past(slice_i) + 4'd1)))
            |-> (hub_we_o || loc_we_o)); // R2

endmodule

// File: tb/hbx_engine_tb.sv
module hbx_engine_tb;

    localparam int DATA_W = 32;
    localparam int HUB_AW = 10;
    localparam int LOC_AW = 8;
    localparam int CNT_W  = 4;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              start_i = 1'b0;
    logic              dir_i = 1'b0;
    logic [HUB_AW-1:0] hub_addr_i = '0;
    logic [LOC_AW-1:0] loc_base_i = '0;
    logic [CNT_W-1:0]  blk_cnt_i = '0;
    logic [3:0]        slice;
    logic              hold = 1'b0;
    logic              busy_o, done_o, hub_we_o, loc_we_o;
    logic [HUB_AW-1:0] hub_addr_o;
    logic [LOC_AW-1:0] loc_addr_o;
    logic [DATA_W-1:0] hub_wdata_o, loc_wdata_o, hub_rdata, loc_rdata;

    logic [DATA_W-1:0] hub_mem [2**HUB_AW];
    logic [DATA_W-1:0] loc_mem [2**LOC_AW];

    typedef struct {
        logic              to_hub;
        logic [HUB_AW-1:0] ha;
        logic [LOC_AW-1:0] la;
        logic [DATA_W-1:0] d;
    } exp_t;
    exp_t sb_q [$];

    int n_chk = 0;
    int n_err = 0;

    always #10 clk = ~clk;

    hbx_engine #(.DATA_W(DATA_W), .HUB_AW(HUB_AW), .LOC_AW(LOC_AW), .CNT_W(CNT_W)) u_dut (
        .clk(clk), .rst(rst), .start_i(start_i), .dir_i(dir_i),
        .hub_addr_i(hub_addr_i), .loc_base_i(loc_base_i), .blk_cnt_i(blk_cnt_i),
        .slice_i(slice), .busy_o(busy_o), .done_o(done_o),
        .hub_addr_o(hub_addr_o), .hub_we_o(hub_we_o), .hub_wdata_o(hub_wdata_o),
        .hub_rdata_i(hub_rdata), .loc_addr_o(loc_addr_o), .loc_we_o(loc_we_o),
        .loc_wdata_o(loc_wdata_o), .loc_rdata_i(loc_rdata)
    );

    // rotator and memory models
    always @(posedge clk) begin
        if (rst) slice <= 4'd0;
        else if (!hold) slice <= slice + 4'd1;
        if (hub_we_o) hub_mem[hub_addr_o] <= hub_wdata_o;
        if (loc_we_o) loc_mem[loc_addr_o] <= loc_wdata_o;
    end
    assign hub_rdata = hub_mem[hub_addr_o];
    assign loc_rdata = loc_mem[loc_addr_o];

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    // scoreboard monitor
    always @(negedge clk) begin
        if (!rst && (hub_we_o || loc_we_o)) begin
            if (sb_q.size() == 0) begin
                chk(1'b0, "R6/R7/R8", "unexpected write strobe", {hub_addr_o, 8'(loc_addr_o)}, 0);
            end else begin
                exp_t e;
                logic [DATA_W-1:0] d;
                e = sb_q.pop_front();
                d = hub_we_o ? hub_wdata_o : loc_wdata_o;
                chk(hub_we_o == e.to_hub && loc_we_o == !e.to_hub, "R4", "direction strobes",
                    {hub_we_o, loc_we_o}, {e.to_hub, !e.to_hub});
                chk(hub_addr_o == e.ha, "R3/R5", "hub word address", 32'(hub_addr_o), 32'(e.ha));
                chk(loc_addr_o == e.la, "R3", "register index", 32'(loc_addr_o), 32'(e.la));
                chk(d == e.d, "R4", "moved data", d, e.d);
            end
        end
    end

    task automatic run_xfer(input logic dir, input logic [HUB_AW-1:0] ha,
                            input logic [LOC_AW-1:0] lb, input int n,
                            input bit stall, input bit poke, input string tag);
        int  cyc = 0;
        bit  seen = 0;
        logic [3:0] s0;
        @(negedge clk);
        dir_i = dir; hub_addr_i = ha; loc_base_i = lb; blk_cnt_i = CNT_W'(n);
        start_i = 1'b1;
        s0 = slice + 4'd1;
        for (int i = 0; i < 16 * n; i++) begin
            exp_t e;
            logic [3:0] s;
            int k;
            k = i / 16;
            s = 4'(s0 + 4'(i));
            e.to_hub = dir;
            e.ha = HUB_AW'({ha[HUB_AW-1:4], 4'b0000} + HUB_AW'(k * 16) + HUB_AW'(s));
            e.la = LOC_AW'(lb + LOC_AW'(k * 16) + LOC_AW'(s));
            e.d  = dir ? loc_mem[e.la] : hub_mem[e.ha];
            sb_q.push_back(e);
        end
        for (int i = 0; i < 16 * n + 8 && !seen; i++) begin
            @(negedge clk);
            start_i = poke && (i == 5);
            if (poke && i == 5) begin
                dir_i = ~dir; hub_addr_i = ha ^ 10'h3F0; blk_cnt_i = 4'd9;
            end
            hold = stall && (i == 3);
            if (busy_o) cyc++;
            if (done_o) begin
                seen = 1;
                chk(!busy_o, "R1", {tag, " busy low at done"}, 32'(busy_o), 0);
            end
        end
        hold = 1'b0;
        start_i = 1'b0;
        chk(seen, "R1", {tag, " done pulse seen"}, 32'(seen), 1);
        chk(cyc == 16 * n + (stall ? 1 : 0), stall ? "R9" : "R1/R2", {tag, " busy cycles"},
            32'(cyc), 32'(16 * n + (stall ? 1 : 0)));
        @(negedge clk);
        chk(!done_o && !busy_o, "R1/R7", {tag, " single done, no restart"},
            {done_o, busy_o}, 0);
        chk(sb_q.size() == 0, "R9", {tag, " every word moved once"}, 32'(sb_q.size()), 0);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_err++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

    initial begin
        for (int a = 0; a < 2**HUB_AW; a++) hub_mem[a] = 32'hC0DE0000 ^ (32'(a) * 32'h9E37);
        for (int a = 0; a < 2**LOC_AW; a++) loc_mem[a] = 32'h5A000000 | (32'(a) * 32'h00010101);
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R8 reset state
        chk(!busy_o && !done_o, "R8", "reset busy/done", {busy_o, done_o}, 0);
        chk(!hub_we_o && !loc_we_o, "R8", "reset strobes", {hub_we_o, loc_we_o}, 0);

        // R1 R2 R3 R4: single block read
        run_xfer(1'b0, 10'h040, 8'h10, 1, 0, 0, "rd1");
        repeat (3) @(negedge clk);
        // R3: three blocks at another phase
        run_xfer(1'b0, 10'h100, 8'h80, 3, 0, 0, "rd3");
        // R4: register file to shared memory, two blocks
        run_xfer(1'b1, 10'h200, 8'h00, 2, 0, 0, "wr2");
        repeat (7) @(negedge clk);
        // R5: unaligned start address
        run_xfer(1'b1, 10'h2C7, 8'h40, 1, 0, 0, "unaligned");
        // R3: register index wraps
        run_xfer(1'b0, 10'h300, 8'hF8, 1, 0, 0, "wrap");
        // R7: start during busy ignored
        run_xfer(1'b0, 10'h180, 8'h20, 2, 0, 1, "poke");
        // R9: rotator stall mid-block
        run_xfer(1'b0, 10'h0C0, 8'h60, 1, 1, 0, "stall");

        // R6: zero count ignored
        begin
            bit act = 0;
            @(negedge clk);
            blk_cnt_i = '0; start_i = 1'b1; dir_i = 1'b1;
            @(negedge clk);
            start_i = 1'b0;
            for (int i = 0; i < 20; i++) begin
                if (busy_o || done_o) act = 1;
                @(negedge clk);
            end
            chk(!act, "R6", "zero count leaves engine idle", 32'(act), 0);
        end

        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

endmodule